// File: doc/BRIEF.md
# Device Enable Control with Status

This block keeps the enable state of up to 32 on-chip peripherals in a small bank of control registers. Each peripheral has a device ID. IDs are grouped into ranges, and the ranges are fixed when the block is elaborated. A range names the register it lives in, its first ID, how many IDs it covers, the bit of its lowest field, the field width per device, and the codes written to enable and to disable a device. A range whose disable code is all ones is write-once: devices in it can be turned on but never off.

A requester presents a device ID and a wanted state. The block performs a read-modify-write of that device's field only. It then watches a status register bank, which models the peripherals: each status field follows its control field after a fixed settling delay and is encoded with its own enable and disable codes from a second range table. When the device's status field shows the requested state, the block pulses `done`. While a request is outstanding, `busy` is high and new requests are dropped. Both register banks can be read back through a select input.

Top module: `dev_enable_ctrl`

## Requirements
- R1: After reset, every control field is zero, `busy` and `done` are low, and the status bank shows each covered device as not enabled: 32'h0000_5500 in status word 0 and 32'h0 in status word 1 for the default tables.
- R2: The field of device `id` sits in its range's register, starting at bit `lsb + width*(id - first)`. Default control ranges are: IDs 0-7 in word 0 at bit 0, 1 bit wide, enable 1, disable 0. IDs 8-11 in word 0 at bit 8, 2 bits wide, enable 2'b11, disable 2'b00. IDs 12-15 in word 0 at bit 16, 1 bit wide, enable 1, enable-only. IDs 20-25 in word 1 at bit 4, 2 bits wide, enable 2'b10, disable 2'b01.
- R3: An accepted request changes only the addressed device's field. It clears the field, then writes the enable or disable code, and leaves all other bits of both control words unchanged.
- R4: In a range whose disable code is 8'hFF (IDs 12-15 by default), a disable request is ignored: control is unchanged, `busy` stays low and no `done` follows.
- R5: Requests for an ID of 32 or more, or for an ID covered by no control range (16-19 and 26-31 by default), are ignored in the same way.
- R6: A status field changes SETTLE (default 8) cycles after its control field. It shows the status-enable code when the control field holds the control-enable code, and the status-disable code otherwise. Default status ranges are: IDs 0-7 in status word 0 from bit 0, 1 bit, codes 1/0. IDs 8-11 in status word 0 from bit 8, 2 bits, enable 2'b10, disable 2'b01. IDs 20-25 in status word 1 from bit 0, 1 bit, codes 1/0.
- R7: `done` is a one-cycle pulse, registered in the cycle after the device's status field first equals the requested code. With the request taken at edge E, that is edge E+SETTLE+1 for a field that changes, and edge E+1 when the status already matches.
- R8: For a device with no status range (IDs 12-15 by default), `done` rises at edge E+1.
- R9: `busy` is high from the accepting edge until `done`. A request presented while `busy` is high is dropped and never written.
- R10: `rd_ctl` and `rd_stat` show control word and status word `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled on the rising edge |
| req_id | input | ID_W (6) | Device ID of the request |
| req_en | input | 1 | 1 requests enable, 0 requests disable |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_sel | input | $clog2(NREG) (1) | Readback word select |
| rd_ctl | output | REG_W (32) | Control word `rd_sel` |
| rd_stat | output | REG_W (32) | Status word `rd_sel` |

## Verification
The bench uses the default parameters: two 32-bit words, four control ranges, three status ranges and a settling delay of 8. This mix gives 1-bit and 2-bit fields in the same word and a range in the second word with nonzero start bit and distinct codes. It also includes an enable-only range without status, and gaps in the ID space with no range at all. With these defaults the bench can reach the status-change timing, the immediate completion of an already-settled or unmonitored device, the ignored disables and unmapped IDs, and the last ID of a range at the top of its field span.

// File: rtl/dev_enable_pkg.sv
package dev_enable_pkg;

   localparam int MAX_RANGES = 8;
   localparam int CODE_W     = 8;
   localparam logic [CODE_W-1:0] LOCK_CODE = '1;

   typedef enum logic {ST_IDLE, ST_WAIT} req_state_t;

   // Value of byte r of a packed range table.
   function automatic int byte_at(logic [MAX_RANGES*8-1:0] v, int r);
      return int'(v[r*8 +: 8]);
   endfunction

   // Lowest range index that covers id, or -1.
   function automatic int range_of_id(int id, logic [MAX_RANGES*8-1:0] first,
                                      logic [MAX_RANGES*8-1:0] cnt, int n);
      int hit;
      hit = -1;
      for (int r = n - 1; r >= 0; r--) begin
         if (id >= byte_at(first, r) && id < byte_at(first, r) + byte_at(cnt, r))
            hit = r;
      end
      return hit;
   endfunction

endpackage

// File: rtl/dev_range_lookup.sv
module dev_range_lookup #(
   parameter int NR   = 4,
   parameter int ID_W = 6,
   parameter int RI_W = 1,
   parameter logic [NR*8-1:0] FIRST = '0,
   parameter logic [NR*8-1:0] COUNT = '0,
   parameter logic [NR*8-1:0] WORD  = '0,
   parameter logic [NR*8-1:0] ENC   = '0,
   parameter logic [NR*8-1:0] DISC  = '0,
   parameter logic [NR*8-1:0] LSB   = '0,
   parameter logic [NR*8-1:0] WIDTH = '0
) (
   input  logic [ID_W-1:0] id,
   output logic            o_hit,
   output logic [RI_W-1:0] o_word,
   output logic [15:0]     o_lsb,
   output logic [7:0]      o_width,
   output logic [7:0]      o_en,
   output logic [7:0]      o_dis
);

   logic [15:0]   id16;
   logic [NR-1:0] hits;

   assign id16 = 16'(id);

   for (genvar r = 0; r < NR; r++) begin : g_cmp
      localparam logic [15:0] LO = 16'(FIRST[r*8 +: 8]);
      localparam logic [15:0] HI = 16'(FIRST[r*8 +: 8]) + 16'(COUNT[r*8 +: 8]);
      assign hits[r] = (id16 >= LO) && (id16 < HI);
   end

   // Lowest-numbered covering range wins.
   always_comb begin
      o_hit   = 1'b0;
      o_word  = '0;
      o_lsb   = '0;
      o_width = '0;
      o_en    = '0;
      o_dis   = '0;
      for (int r = NR - 1; r >= 0; r--) begin
         if (hits[r]) begin
            o_hit   = 1'b1;
            o_word  = RI_W'(WORD[r*8 +: 8]);
            o_width = WIDTH[r*8 +: 8];
            o_en    = ENC[r*8 +: 8];
            o_dis   = DISC[r*8 +: 8];
            o_lsb   = 16'(LSB[r*8 +: 8])
                    + 16'(WIDTH[r*8 +: 8]) * (id16 - 16'(FIRST[r*8 +: 8]));
         end
      end
   end

endmodule

// File: rtl/dev_status_model.sv
module dev_status_model
   import dev_enable_pkg::*;
#(
   parameter int NUM_IDS = 32,
   parameter int NREG    = 2,
   parameter int REG_W   = 32,
   parameter int SETTLE  = 8,
   parameter int NR      = 4,
   parameter int NS      = 3,
   parameter logic [NR*8-1:0] CR_FIRST = '0,
   parameter logic [NR*8-1:0] CR_COUNT = '0,
   parameter logic [NR*8-1:0] CR_WORD  = '0,
   parameter logic [NR*8-1:0] CR_EN    = '0,
   parameter logic [NR*8-1:0] CR_LSB   = '0,
   parameter logic [NR*8-1:0] CR_WIDTH = '0,
   parameter logic [NS*8-1:0] ST_FIRST = '0,
   parameter logic [NS*8-1:0] ST_COUNT = '0,
   parameter logic [NS*8-1:0] ST_WORD  = '0,
   parameter logic [NS*8-1:0] ST_EN    = '0,
   parameter logic [NS*8-1:0] ST_DIS   = '0,
   parameter logic [NS*8-1:0] ST_LSB   = '0,
   parameter logic [NS*8-1:0] ST_WIDTH = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NREG*REG_W-1:0]  ctl_flat,
   output logic [NREG*REG_W-1:0]  stat_flat
);

   localparam int TOT = NREG * REG_W;
   localparam logic [MAX_RANGES*8-1:0] CF = (MAX_RANGES*8)'(CR_FIRST);
   localparam logic [MAX_RANGES*8-1:0] CC = (MAX_RANGES*8)'(CR_COUNT);
   localparam logic [MAX_RANGES*8-1:0] SF = (MAX_RANGES*8)'(ST_FIRST);
   localparam logic [MAX_RANGES*8-1:0] SC = (MAX_RANGES*8)'(ST_COUNT);

   logic [TOT-1:0] dly;
   logic [TOT-1:0] contrib [NUM_IDS];

   // Settling delay: a plain wire for zero, otherwise a register chain.
   if (SETTLE == 0) begin : g_direct
      assign dly = ctl_flat;
   end else begin : g_pipe
      logic [TOT-1:0] stage [SETTLE];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SETTLE; i++) stage[i] <= '0;
         end else begin
            stage[0] <= ctl_flat;
            for (int i = 1; i < SETTLE; i++) stage[i] <= stage[i-1];
         end
      end
      assign dly = stage[SETTLE-1];
   end

   // Per-device status encoder, positions fixed at elaboration.
   for (genvar g = 0; g < NUM_IDS; g++) begin : g_id
      localparam int CI = range_of_id(g, CF, CC, NR);
      localparam int SI = range_of_id(g, SF, SC, NS);
      if (CI >= 0 && SI >= 0) begin : g_live
         localparam int CW = byte_at((MAX_RANGES*8)'(CR_WIDTH), CI);
         localparam int CB = byte_at((MAX_RANGES*8)'(CR_WORD), CI) * REG_W
                           + byte_at((MAX_RANGES*8)'(CR_LSB), CI)
                           + CW * (g - byte_at(CF, CI));
         localparam logic [7:0] CEN = 8'(byte_at((MAX_RANGES*8)'(CR_EN), CI));
         localparam int SW = byte_at((MAX_RANGES*8)'(ST_WIDTH), SI);
         localparam int SB = byte_at((MAX_RANGES*8)'(ST_WORD), SI) * REG_W
                           + byte_at((MAX_RANGES*8)'(ST_LSB), SI)
                           + SW * (g - byte_at(SF, SI));
         localparam logic [7:0] SEN = 8'(byte_at((MAX_RANGES*8)'(ST_EN), SI));
         localparam logic [7:0] SDS = 8'(byte_at((MAX_RANGES*8)'(ST_DIS), SI));
         logic [CW-1:0] cfld;
         logic [SW-1:0] sfld;
         assign cfld       = dly[CB +: CW];
         assign sfld       = (cfld == CEN[CW-1:0]) ? SEN[SW-1:0] : SDS[SW-1:0];
         assign contrib[g] = TOT'(sfld) << SB;
      end else begin : g_none
         assign contrib[g] = '0;
      end
   end

   always_comb begin
      stat_flat = '0;
      for (int g = 0; g < NUM_IDS; g++) stat_flat = stat_flat | contrib[g];
   end

endmodule

// File: rtl/dev_enable_ctrl.sv
module dev_enable_ctrl
   import dev_enable_pkg::*;
#(
   parameter int NUM_IDS = 32,
   parameter int ID_W    = 6,
   parameter int NREG    = 2,
   parameter int REG_W   = 32,
   parameter int SETTLE  = 8,
   parameter int NR      = 4,
   parameter logic [NR*8-1:0] CR_FIRST = {8'd20, 8'd12, 8'd8,  8'd0},
   parameter logic [NR*8-1:0] CR_COUNT = {8'd6,  8'd4,  8'd4,  8'd8},
   parameter logic [NR*8-1:0] CR_WORD  = {8'd1,  8'd0,  8'd0,  8'd0},
   parameter logic [NR*8-1:0] CR_EN    = {8'd2,  8'd1,  8'd3,  8'd1},
   parameter logic [NR*8-1:0] CR_DIS   = {8'd1,  8'hFF, 8'd0,  8'd0},
   parameter logic [NR*8-1:0] CR_LSB   = {8'd4,  8'd16, 8'd8,  8'd0},
   parameter logic [NR*8-1:0] CR_WIDTH = {8'd2,  8'd1,  8'd2,  8'd1},
   parameter int NS      = 3,
   parameter logic [NS*8-1:0] ST_FIRST = {8'd20, 8'd8,  8'd0},
   parameter logic [NS*8-1:0] ST_COUNT = {8'd6,  8'd4,  8'd8},
   parameter logic [NS*8-1:0] ST_WORD  = {8'd1,  8'd0,  8'd0},
   parameter logic [NS*8-1:0] ST_EN    = {8'd1,  8'd2,  8'd1},
   parameter logic [NS*8-1:0] ST_DIS   = {8'd0,  8'd1,  8'd0},
   parameter logic [NS*8-1:0] ST_LSB   = {8'd0,  8'd8,  8'd0},
   parameter logic [NS*8-1:0] ST_WIDTH = {8'd1,  8'd2,  8'd1},
   localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ID_W-1:0]   req_id,
   input  logic              req_en,
   output logic              busy,
   output logic              done,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [REG_W-1:0]  rd_ctl,
   output logic [REG_W-1:0]  rd_stat
);

   localparam int TOT = NREG * REG_W;

   // ---------------- elaboration checks ----------------
   if (NR < 1 || NR > MAX_RANGES || NS < 1 || NS > MAX_RANGES) begin : g_bad_nr
      $error("range table size out of bounds");
   end
   if (NREG < 2 || NUM_IDS > (1 << ID_W)) begin : g_bad_geom
      $error("register count or ID width unsupported");
   end
   for (genvar r = 0; r < NR; r++) begin : g_chk_ctl
      if (int'(CR_FIRST[r*8 +: 8]) + int'(CR_COUNT[r*8 +: 8]) > NUM_IDS ||
          CR_WIDTH[r*8 +: 8] == 8'd0 || CR_WIDTH[r*8 +: 8] > 8'd8 ||
          int'(CR_WORD[r*8 +: 8]) >= NREG ||
          int'(CR_LSB[r*8 +: 8]) + int'(CR_WIDTH[r*8 +: 8]) * int'(CR_COUNT[r*8 +: 8]) > REG_W)
      begin : g_bad
         $error("control range does not fit");
      end
   end
   for (genvar r = 0; r < NS; r++) begin : g_chk_st
      if (int'(ST_FIRST[r*8 +: 8]) + int'(ST_COUNT[r*8 +: 8]) > NUM_IDS ||
          ST_WIDTH[r*8 +: 8] == 8'd0 || ST_WIDTH[r*8 +: 8] > 8'd8 ||
          int'(ST_WORD[r*8 +: 8]) >= NREG ||
          int'(ST_LSB[r*8 +: 8]) + int'(ST_WIDTH[r*8 +: 8]) * int'(ST_COUNT[r*8 +: 8]) > REG_W)
      begin : g_bad
         $error("status range does not fit");
      end
   end

   // ---------------- state ----------------
   req_state_t        state;
   logic [REG_W-1:0]  ctl_q [NREG];
   logic [ID_W-1:0]   pend_id;
   logic              pend_en;
   logic              done_q;
   logic [TOT-1:0]    ctl_flat;
   logic [TOT-1:0]    stat_flat;

   always_comb begin
      for (int i = 0; i < NREG; i++) ctl_flat[i*REG_W +: REG_W] = ctl_q[i];
   end

   // ---------------- request decode ----------------
   logic             c_hit;
   logic [SEL_W-1:0] c_word;
   logic [15:0]      c_lsb;
   logic [7:0]       c_width, c_en, c_dis;

   dev_range_lookup #(
      .NR(NR), .ID_W(ID_W), .RI_W(SEL_W),
      .FIRST(CR_FIRST), .COUNT(CR_COUNT), .WORD(CR_WORD), .ENC(CR_EN),
      .DISC(CR_DIS), .LSB(CR_LSB), .WIDTH(CR_WIDTH)
   ) i_ctl_lookup (
      .id(req_id), .o_hit(c_hit), .o_word(c_word), .o_lsb(c_lsb),
      .o_width(c_width), .o_en(c_en), .o_dis(c_dis)
   );

   logic             id_ok, locked_off, accept;
   logic [7:0]       wr_val;
   logic [REG_W-1:0] fld_ones, wr_mask, wr_code;
   logic [TOT-1:0]   touch_mask;

   assign id_ok      = req_id < ID_W'(NUM_IDS);
   assign locked_off = !req_en && (c_dis == LOCK_CODE);
   assign accept     = req_valid && (state == ST_IDLE) && id_ok && c_hit && !locked_off;
   assign wr_val     = req_en ? c_en : c_dis;
   assign fld_ones   = REG_W'((16'd1 << c_width) - 16'd1);
   assign wr_mask    = fld_ones << c_lsb;
   assign wr_code    = (REG_W'(wr_val) << c_lsb) & wr_mask;
   assign touch_mask = TOT'(wr_mask) << (int'(c_word) * REG_W);

   // ---------------- status model and completion ----------------
   dev_status_model #(
      .NUM_IDS(NUM_IDS), .NREG(NREG), .REG_W(REG_W), .SETTLE(SETTLE),
      .NR(NR), .NS(NS),
      .CR_FIRST(CR_FIRST), .CR_COUNT(CR_COUNT), .CR_WORD(CR_WORD),
      .CR_EN(CR_EN), .CR_LSB(CR_LSB), .CR_WIDTH(CR_WIDTH),
      .ST_FIRST(ST_FIRST), .ST_COUNT(ST_COUNT), .ST_WORD(ST_WORD),
      .ST_EN(ST_EN), .ST_DIS(ST_DIS), .ST_LSB(ST_LSB), .ST_WIDTH(ST_WIDTH)
   ) i_status (
      .clk(clk), .rst_n(rst_n), .ctl_flat(ctl_flat), .stat_flat(stat_flat)
   );

   logic             s_hit;
   logic [SEL_W-1:0] s_word;
   logic [15:0]      s_lsb;
   logic [7:0]       s_width, s_en, s_dis;

   dev_range_lookup #(
      .NR(NS), .ID_W(ID_W), .RI_W(SEL_W),
      .FIRST(ST_FIRST), .COUNT(ST_COUNT), .WORD(ST_WORD), .ENC(ST_EN),
      .DISC(ST_DIS), .LSB(ST_LSB), .WIDTH(ST_WIDTH)
   ) i_stat_lookup (
      .id(pend_id), .o_hit(s_hit), .o_word(s_word), .o_lsb(s_lsb),
      .o_width(s_width), .o_en(s_en), .o_dis(s_dis)
   );

   logic [REG_W-1:0] s_ones, s_word_val;
   logic [7:0]       s_field, s_target;
   logic             stat_match;

   assign s_ones     = REG_W'((16'd1 << s_width) - 16'd1);
   assign s_word_val = stat_flat[int'(s_word)*REG_W +: REG_W];
   assign s_field    = 8'((s_word_val >> s_lsb) & s_ones);
   assign s_target   = (pend_en ? s_en : s_dis) & 8'(s_ones);
   assign stat_match = !s_hit || (s_field == s_target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pend_id <= '0;
         pend_en <= 1'b0;
         done_q  <= 1'b0;
         for (int i = 0; i < NREG; i++) ctl_q[i] <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            ctl_q[c_word] <= (ctl_q[c_word] & ~wr_mask) | wr_code;
            pend_id       <= req_id;
            pend_en       <= req_en;
            state         <= ST_WAIT;
         end else if (state == ST_WAIT && stat_match) begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
         end
      end
   end

   assign busy = (state == ST_WAIT);
   assign done = done_q;

   // ---------------- readback ----------------
   if (NREG == (1 << SEL_W)) begin : g_rd_full
      assign rd_ctl  = ctl_q[rd_sel];
      assign rd_stat = stat_flat[int'(rd_sel)*REG_W +: REG_W];
   end else begin : g_rd_guard
      assign rd_ctl  = (int'(rd_sel) < NREG) ? ctl_q[rd_sel] : '0;
      assign rd_stat = (int'(rd_sel) < NREG) ? stat_flat[int'(rd_sel)*REG_W +: REG_W] : '0;
   end

   // ---------------- assertions ----------------
   assert_rmw_scope_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (((ctl_flat ^ $past(ctl_flat)) & ~$past(touch_mask)) == '0));

   assert_enable_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && c_hit && !req_en && c_dis == LOCK_CODE)
      |=> ($stable(ctl_flat) && !busy));

   assert_unmapped_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && !c_hit) |=> ($stable(ctl_flat) && !busy));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_hold_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ctl_flat));

   assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

endmodule

// File: tb/test_dev_enable_ctrl.sv
module test_dev_enable_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [5:0]  req_id = '0;
   logic        req_en = 1'b0;
   logic        busy, done;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_ctl, rd_stat;

   int vectors = 0;
   int fails   = 0;
   logic [31:0] exp_c0 = '0;
   logic [31:0] exp_c1 = '0;

   int          r_done_at;
   logic        r_busy1;
   logic [31:0] r_pre, r_post;

   always #2.5 clk = ~clk;   // 200 MHz

   dev_enable_ctrl i_dev_enable_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
      .req_en(req_en), .busy(busy), .done(done), .rd_sel(rd_sel),
      .rd_ctl(rd_ctl), .rd_stat(rd_stat)
   );

   // Expected status words derived from control words (R6 encoding).
   function automatic logic [31:0] st0(input logic [31:0] c);
      logic [31:0] s = '0;
      s[7:0] = c[7:0];
      for (int k = 0; k < 4; k++)
         s[8+2*k +: 2] = (c[8+2*k +: 2] == 2'b11) ? 2'b10 : 2'b01;
      return s;
   endfunction

   function automatic logic [31:0] st1(input logic [31:0] c);
      logic [31:0] s = '0;
      for (int k = 0; k < 6; k++) s[k] = (c[4+2*k +: 2] == 2'b10);
      return s;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Issue one request; E is the posedge after which req_valid drops.
   // Negedge n after E lies between edges E+n-1 and E+n.
   task automatic run_req(input int id, input bit en, input bit sel);
      @(negedge clk);
      rd_sel = sel; req_valid = 1'b1; req_id = 6'(id); req_en = en;
      @(negedge clk);
      req_valid = 1'b0;
      r_busy1 = busy;
      r_done_at = done ? 1 : 0;
      r_pre = '0; r_post = '0;
      for (int n = 2; n <= 24; n++) begin
         @(negedge clk);
         if (n == 8) r_pre = rd_stat;
         if (n == 9) r_post = rd_stat;
         if (done && r_done_at == 0) r_done_at = n;
      end
   endtask

   task automatic t_reset;
      @(negedge clk); rd_sel = 1'b0;
      #0.1;
      chk("R1 ctl0", rd_ctl, 32'h0);
      chk("R1 stat0", rd_stat, 32'h0000_5500);
      chk("R1 busy/done", {30'd0, busy, done}, 32'h0);
      @(negedge clk); rd_sel = 1'b1;
      #0.1;
      chk("R1 ctl1", rd_ctl, 32'h0);
      chk("R1 stat1", rd_stat, 32'h0);
   endtask

   task automatic t_enable_bit;
      run_req(3, 1'b1, 1'b0);
      chk("R9 busy after accept", {31'd0, r_busy1}, 32'd1);
      chk("R6 status before settle", r_pre, st0(exp_c0));
      exp_c0 = exp_c0 | 32'h8;
      chk("R6 status after settle", r_post, st0(exp_c0));
      chk("R7 done timing", r_done_at, 10);
      chk("R2 ctl0 id3", rd_ctl, exp_c0);
   endtask

   task automatic t_enable_wide;
      run_req(9, 1'b1, 1'b0);
      exp_c0 = exp_c0 | 32'h0000_0C00;   // bits 11:10 = 2'b11
      chk("R2 ctl0 id9", rd_ctl, exp_c0);
      chk("R6 wide status", r_post, st0(exp_c0));
      chk("R7 done wide", r_done_at, 10);
   endtask

   task automatic t_enable_only;
      run_req(14, 1'b1, 1'b0);
      exp_c0 = exp_c0 | 32'h0004_0000;   // bit 18
      chk("R2 ctl0 id14", rd_ctl, exp_c0);
      chk("R8 done no status", r_done_at, 2);
      chk("R8 status untouched", r_post, st0(exp_c0));
      run_req(14, 1'b0, 1'b0);
      chk("R4 disable ignored ctl", rd_ctl, exp_c0);
      chk("R4 no busy", {31'd0, r_busy1}, 32'd0);
      chk("R4 no done", r_done_at, 0);
   endtask

   task automatic t_word1;
      run_req(22, 1'b1, 1'b1);
      exp_c1 = 32'h0000_0200;            // bits 9:8 = 2'b10
      chk("R2 ctl1 id22 on", rd_ctl, exp_c1);
      chk("R6 stat1 on", r_post, st1(exp_c1));
      chk("R7 done id22 on", r_done_at, 10);
      run_req(22, 1'b0, 1'b1);
      exp_c1 = 32'h0000_0100;            // bits 9:8 = 2'b01
      chk("R3 ctl1 id22 off", rd_ctl, exp_c1);
      chk("R6 stat1 off pre", r_pre, 32'h4);
      chk("R6 stat1 off", r_post, st1(exp_c1));
      chk("R7 done id22 off", r_done_at, 10);
      run_req(25, 1'b1, 1'b1);
      exp_c1 = exp_c1 | 32'h0000_8000;   // last device: bits 15:14
      chk("R2 ctl1 id25", rd_ctl, exp_c1);
      chk("R6 stat1 id25", r_post, 32'h20);
   endtask

   task automatic t_disable_keep_others;
      run_req(3, 1'b0, 1'b0);
      exp_c0 = exp_c0 & ~32'h8;
      chk("R3 ctl0 after disable", rd_ctl, exp_c0);
      chk("R7 done disable", r_done_at, 10);
      run_req(9, 1'b1, 1'b0);
      chk("R7 already settled", r_done_at, 2);
      chk("R3 ctl0 unchanged", rd_ctl, exp_c0);
   endtask

   task automatic t_ignored_ids;
      run_req(17, 1'b1, 1'b0);
      chk("R5 gap id busy", {31'd0, r_busy1}, 32'd0);
      chk("R5 gap id done", r_done_at, 0);
      chk("R5 gap id ctl0", rd_ctl, exp_c0);
      run_req(40, 1'b1, 1'b1);
      chk("R5 high id done", r_done_at, 0);
      chk("R5 high id ctl1", rd_ctl, exp_c1);
   endtask

   task automatic t_busy_block;
      int done_at = 0;
      @(negedge clk);
      rd_sel = 1'b0; req_valid = 1'b1; req_id = 6'd0; req_en = 1'b1;
      for (int n = 1; n <= 24; n++) begin
         @(negedge clk);
         req_valid = (n == 3);
         req_id    = (n == 3) ? 6'd1 : 6'd0;
         if (n == 5) chk("R9 busy mid wait", {31'd0, busy}, 32'd1);
         if (done && done_at == 0) done_at = n;
      end
      req_valid = 1'b0;
      exp_c0 = exp_c0 | 32'h1;
      chk("R9 done first request", done_at, 10);
      chk("R9 second request dropped", rd_ctl, exp_c0);
   endtask

   task automatic t_readback;
      @(negedge clk); rd_sel = 1'b0;
      #0.1;
      chk("R10 word0 ctl", rd_ctl, exp_c0);
      chk("R10 word0 stat", rd_stat, st0(exp_c0));
      @(negedge clk); rd_sel = 1'b1;
      #0.1;
      chk("R10 word1 ctl", rd_ctl, exp_c1);
      chk("R10 word1 stat", rd_stat, st1(exp_c1));
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_enable_bit();
      t_enable_wide();
      t_enable_only();
      t_word1();
      t_disable_keep_others();
      t_ignored_ids();
      t_busy_block();
      t_readback();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule